// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB-style video output. Software programs, through a plain register write port, the active width and height and, for each direction, the sync width, back porch and front porch. Every count is stored as the real count minus one. From these values the block drives horizontal sync, vertical sync and data-enable, and it gives the pixel column and row inside the active area. It also reports the current vertical phase, keeps a frame counter that advances each time vertical sync starts, and raises a frame interrupt when the raster enters a vertical phase that software selects.

Timing values are copied into a shadow set only at a frame start, so a frame already in flight always finishes with the values it began with. When an enable bit is cleared, the current frame runs to its end and the output then stops; a stop-status pin stays high in the meantime. In interlaced mode the vertical back porch is halved and a field bit alternates from frame to frame; the frame interrupt is then taken only in field 0. A software reset stops the output and clears the frame counter. No data stream passes through the block, so it has no valid/ready handshake; all pins are plain control and status.

Register map, with data bits [CW-1:0]: address 0 is the control register (bit 0 output enable, bit 1 frame enable, bit 2 interlace, bit 3 software reset). Address 1 is the interrupt configuration (bit 0 global enable, bits [2:1] the phase that triggers). Address 2 is the interrupt clear (write 1 to bit 0). Addresses 3 to 10 hold the timing fields: horizontal sync, back porch, active, front porch, then vertical sync, back porch, active, front porch.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, hsync, vsync, de, px_x, px_y, frame_id, field, irq, stop_status and reset_busy are all 0, and vphase is 0.
- R2: Each line runs sync (HSW+1 cycles, hsync high), then back porch (HBP+1), then active (HACT+1, px_x counting 0 up to HACT), then front porch (HFP+1), and then repeats.
- R3: Each frame runs the same order, counted in lines: sync (VSW+1 lines, vsync high), back porch, active (VACT+1 lines, px_y counting up), front porch (VFP+1). vphase shows 0 for sync, 1 for back porch, 2 for active and 3 for front porch. de is high only when both directions are active.
- R4: Timing starts only when the output enable (control bit 0) and the frame enable (control bit 1) are both set. With only one of them set, the outputs stay idle.
- R5: A write to a timing register takes effect at the next frame start. The frame in progress keeps its old values.
- R6: frame_id advances by one, modulo 2^FIDW, in the first cycle of every frame, which is the cycle in which vsync and hsync begin.
- R7: When either enable is cleared during output, stop_status is high until the current frame ends. The output then goes idle without starting another frame.
- R8: Writing 1 to control bit 3 stops the output at once and clears frame_id, field, the pending interrupt, the control bits and the interrupt configuration. reset_busy is then high for RST_CYC cycles, and register writes are ignored while it is high.
- R9: With interlace (control bit 2) set, the vertical back porch lasts max(1, floor((VBP+1)/2)) lines. field is 0 in the first frame after start and toggles at every later frame start.
- R10: The interrupt becomes pending, and irq goes high, in the cycle in which vphase enters the phase chosen by interrupt-configuration bits [2:1]. This happens only while the global enable (bit 0) is set. Writing 1 to bit 0 of address 2 clears it, and a new event in the same cycle wins over the clear.
- R11: In interlaced mode, phase entries that occur in field 1 never set the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register address |
| wr_data | input | CW | Register write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| px_x | output | CW | Column inside the active area |
| px_y | output | CW | Row inside the active area |
| vphase | output | 2 | Vertical phase: 0 sync, 1 back porch, 2 active, 3 front porch |
| frame_id | output | FIDW | Frame counter |
| field | output | 1 | Current interlace field |
| irq | output | 1 | Frame interrupt pending |
| stop_status | output | 1 | Output still running after an enable was cleared |
| reset_busy | output | 1 | Software reset in progress |

## Verification
The bound checker checks, on every cycle, the rules that hold at any instant. de only appears in the vertical active phase with both syncs low. frame_id moves only by one, or back to zero, and only in a cycle where both syncs are high. Everything stays quiet while reset_busy is high, and irq only rises after the global enable was set. Shadow-register timing, halving of the back porch, field-gated interrupts, and the sequence in which a frame drains after an enable is cleared depend on the order of register writes relative to the raster. Only the bench's scenarios can show these, and there a behavioural model that tracks linear positions is compared against every output on every clock.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  // register addresses
  localparam int unsigned A_CTRL   = 0;
  localparam int unsigned A_IRQCFG = 1;
  localparam int unsigned A_IRQCLR = 2;
  localparam int unsigned A_TIM0   = 3;

  // control bits
  localparam int unsigned B_OE  = 0;
  localparam int unsigned B_FE  = 1;
  localparam int unsigned B_IL  = 2;
  localparam int unsigned B_SWR = 3;

  // timing field slots, offset from A_TIM0
  localparam int unsigned NTIM  = 8;
  localparam int unsigned T_HSW = 0;
  localparam int unsigned T_HBP = 1;
  localparam int unsigned T_HAC = 2;
  localparam int unsigned T_HFP = 3;
  localparam int unsigned T_VSW = 4;
  localparam int unsigned T_VBP = 5;
  localparam int unsigned T_VAC = 6;
  localparam int unsigned T_VFP = 7;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned CW      = 12,
  parameter int unsigned AW      = 4,
  parameter int unsigned RST_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [CW-1:0]             wr_data,
  output logic                      out_en,
  output logic                      frm_en,
  output logic                      ilace,
  output logic                      gie,
  output logic [1:0]                irq_sel,
  output logic                      irq_clr,
  output logic                      sw_rst,
  output logic                      busy,
  output logic [NTIM-1:0][CW-1:0]   tim
);
  localparam int unsigned RCW = $clog2(RST_CYC + 1);

  logic [RCW-1:0] rcnt;
  logic           wr_ok;
  logic           hold;

  assign busy    = (rcnt != '0);
  assign wr_ok   = wr_en & ~busy;
  assign sw_rst  = wr_ok & (wr_addr == AW'(A_CTRL)) & wr_data[B_SWR];
  assign hold    = sw_rst | busy;
  assign irq_clr = wr_ok & (wr_addr == AW'(A_IRQCLR)) & wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rcnt <= '0;
    else if (sw_rst) rcnt <= RCW'(RST_CYC);
    else if (busy)   rcnt <= rcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_en <= 1'b0;
      frm_en <= 1'b0;
      ilace  <= 1'b0;
    end else if (hold) begin
      out_en <= 1'b0;
      frm_en <= 1'b0;
      ilace  <= 1'b0;
    end else if (wr_ok && wr_addr == AW'(A_CTRL)) begin
      out_en <= wr_data[B_OE];
      frm_en <= wr_data[B_FE];
      ilace  <= wr_data[B_IL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie     <= 1'b0;
      irq_sel <= 2'd0;
    end else if (hold) begin
      gie     <= 1'b0;
      irq_sel <= 2'd0;
    end else if (wr_ok && wr_addr == AW'(A_IRQCFG)) begin
      gie     <= wr_data[0];
      irq_sel <= wr_data[2:1];
    end
  end

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tim[g] <= '0;
      else if (wr_ok && wr_addr == AW'(A_TIM0 + g)) tim[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rtg_phase_ctr.sv
module rtg_phase_ctr
  import rtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                adv,
  input  logic [3:0][CW-1:0]  lim,
  output phase_e              phase,
  output logic [CW-1:0]       cnt,
  output logic                at_lim,
  output logic                last
);
  assign at_lim = (cnt == lim[2'(phase)]);
  assign last   = at_lim & (phase == PH_FRONT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (clr) begin
      phase <= PH_SYNC;
      cnt   <= '0;
    end else if (adv) begin
      if (at_lim) begin
        phase <= phase_e'(2'(phase) + 2'd1);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned CW      = 12,
  parameter int unsigned AW      = 4,
  parameter int unsigned FIDW    = 16,
  parameter int unsigned RST_CYC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [CW-1:0]   wr_data,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic [CW-1:0]   px_x,
  output logic [CW-1:0]   px_y,
  output logic [1:0]      vphase,
  output logic [FIDW-1:0] frame_id,
  output logic            field,
  output logic            irq,
  output logic            stop_status,
  output logic            reset_busy
);
  logic out_en, frm_en, ilace, gie, irq_clr, sw_rst, busy;
  logic [1:0] irq_sel;
  logic [NTIM-1:0][CW-1:0] tim, sh;
  logic sh_il;

  rtg_regs #(.CW(CW), .AW(AW), .RST_CYC(RST_CYC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_en(out_en), .frm_en(frm_en), .ilace(ilace), .gie(gie), .irq_sel(irq_sel),
    .irq_clr(irq_clr), .sw_rst(sw_rst), .busy(busy), .tim(tim)
  );

  // interlaced back porch: max(1, floor((VBP+1)/2)) lines, stored minus one
  logic [CW:0]   vbp_half;
  logic [CW-1:0] vbp_eff;
  always_comb begin
    vbp_half = ({1'b0, sh[T_VBP]} + 1'b1) >> 1;
    if (!sh_il)              vbp_eff = sh[T_VBP];
    else if (vbp_half == '0) vbp_eff = '0;
    else                     vbp_eff = CW'(vbp_half - 1'b1);
  end

  logic [3:0][CW-1:0] h_lim, v_lim;
  assign h_lim = {sh[T_HFP], sh[T_HAC], sh[T_HBP], sh[T_HSW]};
  assign v_lim = {sh[T_VFP], sh[T_VAC], vbp_eff, sh[T_VSW]};

  logic running, pend;
  logic hold, run_req, launch, cont, start, frame_end, ctr_clr;
  phase_e h_ph, v_ph;
  logic [CW-1:0] h_cnt, v_cnt;
  logic h_at, h_last, v_at, v_last;

  assign hold      = sw_rst | busy;
  assign run_req   = out_en & frm_en;
  assign ctr_clr   = ~running | hold;
  assign frame_end = running & h_last & v_last;
  assign launch    = ~running & run_req & ~hold;
  assign cont      = frame_end & run_req & ~hold;
  assign start     = launch | cont;

  rtg_phase_ctr #(.CW(CW)) u_hctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .adv(running), .lim(h_lim),
    .phase(h_ph), .cnt(h_cnt), .at_lim(h_at), .last(h_last)
  );

  rtg_phase_ctr #(.CW(CW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .adv(running & h_last), .lim(v_lim),
    .phase(v_ph), .cnt(v_cnt), .at_lim(v_at), .last(v_last)
  );

  // run control and shadow capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sh      <= '0;
      sh_il   <= 1'b0;
    end else begin
      if (hold)                       running <= 1'b0;
      else if (launch)                running <= 1'b1;
      else if (frame_end && !run_req) running <= 1'b0;
      if (start) begin
        sh    <= tim;
        sh_il <= ilace;
      end
    end
  end

  // field, frame counter and interrupt
  logic field_nx, il_nx, v_step_ph, enter_ev, irq_set;
  phase_e v_next;
  always_comb begin
    if (hold || launch) field_nx = 1'b0;
    else if (cont)      field_nx = ilace & ~field;
    else                field_nx = field;
    il_nx     = start ? ilace : sh_il;
    v_next    = phase_e'(2'(v_ph) + 2'd1);
    v_step_ph = running & h_last & v_at & (v_ph != PH_FRONT);
    enter_ev  = (start & (irq_sel == 2'(PH_SYNC))) |
                (v_step_ph & (2'(v_next) == irq_sel));
    irq_set   = gie & enter_ev & ~hold & ~(il_nx & field_nx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field    <= 1'b0;
      frame_id <= '0;
      pend     <= 1'b0;
    end else begin
      field <= field_nx;
      if (hold)       frame_id <= '0;
      else if (start) frame_id <= frame_id + 1'b1;
      if (hold)         pend <= 1'b0;
      else if (irq_set) pend <= 1'b1;
      else if (irq_clr) pend <= 1'b0;
    end
  end

  assign hsync       = running & (h_ph == PH_SYNC);
  assign vsync       = running & (v_ph == PH_SYNC);
  assign de          = running & (h_ph == PH_ACT) & (v_ph == PH_ACT);
  assign px_x        = (running && h_ph == PH_ACT) ? h_cnt : '0;
  assign px_y        = (running && v_ph == PH_ACT) ? v_cnt : '0;
  assign vphase      = v_ph;
  assign irq         = pend;
  assign stop_status = running & ~run_req;
  assign reset_busy  = busy;
endmodule

// File: rtl/rtg_chk.sv
module rtg_chk #(
  parameter int unsigned FIDW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hsync,
  input logic            vsync,
  input logic            de,
  input logic [1:0]      vphase,
  input logic [FIDW-1:0] frame_id,
  input logic            irq,
  input logic            reset_busy,
  input logic            stop_status,
  input logic            cfg_gie
);
  // R3
  de_in_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (vphase == 2'd2 && !hsync && !vsync));

  // R6
  fid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_id != $past(frame_id)) |->
      (frame_id == '0 || frame_id == $past(frame_id) + 1'b1));

  // R6
  fid_at_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_id != $past(frame_id) && frame_id != '0) |-> (hsync && vsync));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_busy |-> (!hsync && !vsync && !de && frame_id == '0 && !irq && !stop_status));

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cfg_gie));
endmodule

bind raster_timing_gen rtg_chk #(.FIDW(FIDW)) u_rtg_chk (
  .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync), .de(de),
  .vphase(vphase), .frame_id(frame_id), .irq(irq), .reset_busy(reset_busy),
  .stop_status(stop_status), .cfg_gie(gie)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam int FIDW = 16;
  localparam int RST_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic hsync, vsync, de, field, irq, stop_status, reset_busy;
  logic [CW-1:0] px_x, px_y;
  logic [1:0] vphase;
  logic [FIDW-1:0] frame_id;

  raster_timing_gen #(.CW(CW), .AW(AW), .FIDW(FIDW), .RST_CYC(RST_CYC)) u_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y), .vphase(vphase),
    .frame_id(frame_id), .field(field), .irq(irq), .stop_status(stop_status),
    .reset_busy(reset_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mr_oe, mr_fe, mr_il, mr_gie, mr_sel;
  int mr_tim[8];
  int sh[8];
  int sh_il;
  int m_run, m_h, m_v, m_field, m_fid, m_pend, m_busy;

  function automatic int seg(int p, int a, int b, int c);
    if (p < a) return 0;
    if (p < a + b) return 1;
    if (p < a + b + c) return 2;
    return 3;
  endfunction

  function automatic int vbp_lines();
    if (sh_il == 0) return sh[5] + 1;
    return ((sh[5] + 1) / 2 < 1) ? 1 : (sh[5] + 1) / 2;
  endfunction

  function automatic int hph_of(int p);
    return seg(p, sh[0] + 1, sh[1] + 1, sh[2] + 1);
  endfunction

  function automatic int vph_of(int p);
    return seg(p, sh[4] + 1, vbp_lines(), sh[6] + 1);
  endfunction

  always @(posedge clk) begin : mdl
    int htot, vtot, nh, nv, nrun, nfld, ovph, nvph;
    bit swr, bsy, fend, req, lau, con, ev, clr;
    if (!rst_n) begin
      mr_oe = 0; mr_fe = 0; mr_il = 0; mr_gie = 0; mr_sel = 0;
      for (int i = 0; i < 8; i++) begin mr_tim[i] = 0; sh[i] = 0; end
      sh_il = 0; m_run = 0; m_h = 0; m_v = 0; m_field = 0; m_fid = 0; m_pend = 0; m_busy = 0;
    end else begin
      swr  = wr_en && wr_addr == 0 && wr_data[3] && m_busy == 0;
      bsy  = swr || m_busy > 0;
      htot = sh[0] + sh[1] + sh[2] + sh[3] + 4;
      vtot = sh[4] + vbp_lines() + sh[6] + sh[7] + 3;
      fend = m_run != 0 && m_h == htot - 1 && m_v == vtot - 1;
      req  = mr_oe != 0 && mr_fe != 0;
      lau  = m_run == 0 && req && !bsy;
      con  = fend && req && !bsy;
      ovph = (m_run != 0) ? vph_of(m_v) : 0;
      nh = m_h; nv = m_v; nrun = m_run; nfld = m_field;
      if (bsy) begin
        nrun = 0; nh = 0; nv = 0; nfld = 0;
      end else if (lau) begin
        nrun = 1; nh = 0; nv = 0; nfld = 0;
        for (int i = 0; i < 8; i++) sh[i] = mr_tim[i];
        sh_il = mr_il;
      end else if (m_run != 0) begin
        nh = m_h + 1;
        if (nh == htot) begin
          nh = 0; nv = m_v + 1;
          if (nv == vtot) nv = 0;
        end
        if (fend) begin
          if (con) begin
            for (int i = 0; i < 8; i++) sh[i] = mr_tim[i];
            sh_il = mr_il;
            nfld = (mr_il != 0) ? 1 - m_field : 0;
          end else nrun = 0;
        end
      end
      nvph = (nrun != 0) ? vph_of(nv) : 0;
      ev  = nrun != 0 && nvph == mr_sel && (lau || con || nvph != ovph) &&
            mr_gie != 0 && !(sh_il != 0 && nfld == 1);
      clr = wr_en && wr_addr == 2 && wr_data[0] && m_busy == 0;
      if (bsy) m_pend = 0;
      else if (ev) m_pend = 1;
      else if (clr) m_pend = 0;
      if (bsy) m_fid = 0;
      else if (lau || con) m_fid = (m_fid + 1) % (1 << FIDW);
      if (bsy) begin
        mr_oe = 0; mr_fe = 0; mr_il = 0; mr_gie = 0; mr_sel = 0;
      end else if (wr_en) begin
        if (wr_addr == 0) begin
          mr_oe = wr_data[0]; mr_fe = wr_data[1]; mr_il = wr_data[2];
        end else if (wr_addr == 1) begin
          mr_gie = wr_data[0]; mr_sel = int'(wr_data[2:1]);
        end else if (wr_addr >= 3 && wr_addr <= 10) begin
          mr_tim[wr_addr - 3] = int'(wr_data);
        end
      end
      if (swr) m_busy = RST_CYC;
      else if (m_busy > 0) m_busy--;
      m_run = nrun; m_h = nh; m_v = nv; m_field = nfld;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin : cmp
    int hp, vp;
    if (rst_n) begin
      hp = hph_of(m_h);
      vp = vph_of(m_v);
      check("R2 hsync", int'(hsync), (m_run != 0 && hp == 0) ? 1 : 0);
      check("R2 px_x", int'(px_x), (m_run != 0 && hp == 2) ? m_h - sh[0] - sh[1] - 2 : 0);
      check("R3 vsync", int'(vsync), (m_run != 0 && vp == 0) ? 1 : 0);
      check("R3 de", int'(de), (m_run != 0 && hp == 2 && vp == 2) ? 1 : 0);
      check("R3 px_y", int'(px_y), (m_run != 0 && vp == 2) ? m_v - sh[4] - 1 - vbp_lines() : 0);
      check("R3 vphase", int'(vphase), (m_run != 0) ? vp : 0);
      check("R6 frame_id", int'(frame_id), m_fid);
      check("R9 field", int'(field), m_field);
      check("R10 irq", int'(irq), m_pend);
      check("R7 stop_status", int'(stop_status), (m_run != 0 && !(mr_oe != 0 && mr_fe != 0)) ? 1 : 0);
      check("R8 reset_busy", int'(reset_busy), (m_busy > 0) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_fid_change();
    int s = int'(frame_id);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (int'(frame_id) != s) break;
    end
  endtask

  task automatic count_frame(output int nde, output int nbp);
    int s = int'(frame_id);
    nde = 0; nbp = 0;
    for (int i = 0; i < 5000; i++) begin
      if (de) nde++;
      if (vphase == 2'd1) nbp++;
      @(negedge clk);
      if (int'(frame_id) != s) break;
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int nde, nbp, cnt, saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 hsync", int'(hsync), 0);
    check("R1 vsync", int'(vsync), 0);
    check("R1 de", int'(de), 0);
    check("R1 frame_id", int'(frame_id), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 vphase", int'(vphase), 0);
    check("R1 reset_busy", int'(reset_busy), 0);

    // timing: HSW 2, HBP 3, HACT 9, HFP 2; VSW 1, VBP 4, VACT 5, VFP 2
    wr(3, 1); wr(4, 2); wr(5, 8); wr(6, 1);
    wr(7, 0); wr(8, 3); wr(9, 4); wr(10, 1);
    wr(1, 1 | (2 << 1));   // gie, trigger on active phase

    // R4 only the output enable
    wr(0, 1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (hsync) cnt++;
    end
    check("R4 no sync with one enable", cnt, 0);
    check("R4 frame_id idle", int'(frame_id), 0);

    wr(0, 3);
    wait_fid_change();
    check("R6 first frame id", int'(frame_id), 1);
    count_frame(nde, nbp);
    check("R3 de per frame", nde, 45);
    check("R9 progressive back porch cycles", nbp, 64);

    // R10 clear, then set on entry to active
    wr(2, 1);
    check("R10 cleared", int'(irq), 0);
    for (int i = 0; i < 3000; i++) begin
      if (vphase == 2'd2) break;
      @(negedge clk);
    end
    check("R10 set on active entry", int'(irq), 1);

    // R5 mid-frame width change applies next frame
    wait_fid_change();
    wr(5, 5);
    count_frame(nde, nbp);
    check("R5 old width kept", nde, 45);
    count_frame(nde, nbp);
    check("R5 new width applied", nde, 30);

    // R7 clear frame enable mid-frame
    repeat (20) @(negedge clk);
    saved = int'(frame_id);
    wr(0, 1);
    check("R7 stop_status high", int'(stop_status), 1);
    for (int i = 0; i < 3000; i++) begin
      if (!stop_status) break;
      @(negedge clk);
    end
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hsync || de) cnt++;
    end
    check("R7 idle after drain", cnt, 0);
    check("R7 no new frame", int'(frame_id), saved);

    // R8 software reset while running
    wr(0, 3);
    wait_fid_change();
    repeat (30) @(negedge clk);
    wr(0, 8);
    check("R8 busy", int'(reset_busy), 1);
    check("R8 frame_id cleared", int'(frame_id), 0);
    check("R8 output stopped", int'(hsync), 0);
    wr(5, 2);              // ignored while busy
    repeat (RST_CYC + 2) @(negedge clk);
    check("R8 busy ended", int'(reset_busy), 0);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hsync) cnt++;
    end
    check("R8 control cleared", cnt, 0);

    // R9 / R11 interlaced, interrupt on sync entry
    wr(1, 1);
    wr(0, 7);
    for (int f = 0; f < 4; f++) begin
      wait_fid_change();
      check("R11 irq per field", int'(irq), (f % 2 == 0) ? 1 : 0);
      if (irq) wr(2, 1);
    end
    wait_fid_change();
    count_frame(nde, nbp);
    check("R8 ignored write, width kept", nde, 30);
    check("R9 halved back porch cycles", nbp, 26);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule